// File: doc/BRIEF.md
# Pulse-Width Trigger Separator

Each detector delivers its trigger on one wire. Two kinds of hit share that wire, and only the pulse duration tells them apart. A main-detector hit is roughly 50 ns long. An overlap-detector hit is roughly 25 ns long. The block samples eight such lines with a fast clock: 400 MHz, one sample every 2.5 ns. It counts how many samples each pulse stays high and sorts the pulse into one of two trigger outputs for its channel. Pulses that are too short are discarded as glitches.

A long pulse is classified as soon as its sample count reaches a programmable threshold, so the main-detector trigger does not wait for the falling edge. This keeps the latency inside the budget of about one and a half bunch crossings. A short pulse is classified at its falling edge.

Results are handed to the downstream trigger processor aligned to the bunch crossing, which is 25 ns, or ten samples. A one-sample strobe `bc_tick` marks the last fast cycle of each crossing. Every output also drives a saturating event counter. Software reads these counters through a select input and clears all of them with one write strobe.

Top module: `pulse_width_sep`

## Requirements
- R1: After reset, `main_trig` and `ovl_trig` are all low and every event counter reads zero.
- R2: A pulse that stays high for at least `long_thr` samples gives exactly one main-detector event and no overlap event. The main output rises while the input is still high.
- R3: A pulse whose length is at least MIN_W samples (default 6) and below `long_thr` gives exactly one overlap event and no main event.
- R4: A pulse shorter than MIN_W samples gives no event on either output.
- R5: `long_thr` sets the main/overlap boundary at run time. Valid values run from MIN_W+1 to 2**TW-1, and the default setting is 15.
- R6: Outputs change only in the fast cycle after `bc_tick`. Each detected event holds its output high for exactly one bunch period, which is ten samples between ticks.
- R7: A pulse that starts after fewer than GAP low samples (default 2) following the previous pulse is ignored entirely. With GAP or more low samples, the pulse is accepted.
- R8: Channels are classified independently; a pulse on one channel never changes another channel's outputs or counters.
- R9: Each counter grows by one for each bunch period in which its output is raised. `rd_addr` = 2*channel + kind selects the counter, where kind 0 is main and kind 1 is overlap.
- R10: A counter that reaches all ones stays there.
- R11: A one-cycle `ctr_clr` sets every counter to zero on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bc_tick | input | 1 | One-cycle strobe marking each bunch-crossing boundary |
| hit_in | input | NCH | Raw trigger line per detector channel |
| long_thr | input | TW | Sample count at which a pulse is classed as main-detector |
| ctr_clr | input | 1 | Clears all event counters |
| rd_addr | input | $clog2(2*NCH) | Counter select: 2*channel + kind |
| main_trig | output | NCH | Main-detector trigger per channel, bunch aligned |
| ovl_trig | output | NCH | Overlap-detector trigger per channel, bunch aligned |
| rd_data | output | CNT_W | Selected counter value |

## Verification
The assertions check the following on every cycle:
- Outputs move only after a bunch tick.
- Each counter either holds its value or steps by one.
- A counter steps exactly when its output is raised at a tick, and a full counter does not wrap.
- A clear empties every counter.

Only the directed scenarios can show whether a pulse lands in the right class:
- The threshold edges at MIN_W and `long_thr`.
- The glitch rejection.
- The re-arming rule after one versus two low samples.
- The channel independence.
- The full ten-cycle hold of each event.

// File: rtl/pulse_width_sep.sv
module pulse_width_sep #(
  parameter int NCH   = 8,
  parameter int CNT_W = 32,
  parameter int TW    = 5,
  parameter int MIN_W = 6,
  parameter int GAP   = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bc_tick,
  input  logic [NCH-1:0]                hit_in,
  input  logic [TW-1:0]                 long_thr,
  input  logic                          ctr_clr,
  input  logic [$clog2(2*NCH)-1:0]      rd_addr,
  output logic [NCH-1:0]                main_trig,
  output logic [NCH-1:0]                ovl_trig,
  output logic [CNT_W-1:0]              rd_data
);
  localparam int NCTR = 2 * NCH;
  localparam int GW   = $clog2(GAP + 1);

  logic [NCH-1:0] fire_m, fire_o, pend_m, pend_o;
  logic [NCTR-1:0] inc;
  logic [NCTR-1:0][CNT_W-1:0] cnt;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic          din_q, in_p, long_done;
    logic [TW-1:0] wcnt;
    logic [GW-1:0] lcnt;

    assign fire_m[i] = in_p && din_q && !long_done && (wcnt == long_thr - TW'(1));
    assign fire_o[i] = in_p && !din_q && !long_done && (int'(wcnt) >= MIN_W);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        din_q     <= 1'b0;
        in_p      <= 1'b0;
        long_done <= 1'b0;
        wcnt      <= '0;
        lcnt      <= GW'(GAP);
      end else begin
        din_q <= hit_in[i];
        if (!in_p) begin
          if (din_q && int'(lcnt) >= GAP) begin
            in_p <= 1'b1;
            wcnt <= TW'(1);
          end
          if (din_q) lcnt <= '0;
          else if (int'(lcnt) < GAP) lcnt <= lcnt + GW'(1);
        end else if (din_q) begin
          if (wcnt != '1) wcnt <= wcnt + TW'(1);
          if (fire_m[i]) long_done <= 1'b1;
        end else begin
          in_p      <= 1'b0;
          long_done <= 1'b0;
          lcnt      <= GW'(1);
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_m[i]    <= 1'b0;
        pend_o[i]    <= 1'b0;
        main_trig[i] <= 1'b0;
        ovl_trig[i]  <= 1'b0;
      end else begin
        pend_m[i] <= fire_m[i] | (pend_m[i] & ~bc_tick);
        pend_o[i] <= fire_o[i] | (pend_o[i] & ~bc_tick);
        if (bc_tick) begin
          main_trig[i] <= pend_m[i];
          ovl_trig[i]  <= pend_o[i];
        end
      end
    end

    assign inc[2*i]   = bc_tick & pend_m[i];
    assign inc[2*i+1] = bc_tick & pend_o[i];
  end

  for (genvar k = 0; k < NCTR; k++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n || ctr_clr) cnt[k] <= '0;
      else if (inc[k] && cnt[k] != '1) cnt[k] <= cnt[k] + CNT_W'(1);
    end
  end

  assign rd_data = (int'(rd_addr) < NCTR) ? cnt[rd_addr] : '0;
endmodule

module pulse_width_sep_chk #(
  parameter int NCH   = 8,
  parameter int CNT_W = 32
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           bc_tick,
  input logic                           ctr_clr,
  input logic [NCH-1:0]                 main_trig,
  input logic [NCH-1:0]                 ovl_trig,
  input logic [2*NCH-1:0][CNT_W-1:0]    cnt
);
  AST_OUT_BC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    !bc_tick |=> ($stable(main_trig) && $stable(ovl_trig))); // R6

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_clr |=> (cnt == '0)); // R11

  for (genvar k = 0; k < 2*NCH; k++) begin : g_k
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !ctr_clr |=> (cnt[k] == $past(cnt[k]) || cnt[k] == $past(cnt[k]) + CNT_W'(1))); // R9
    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctr_clr && cnt[k] == '1) |=> (cnt[k] == '1)); // R10
  end

  for (genvar i = 0; i < NCH; i++) begin : g_i
    AST_CNT_TRACKS_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctr_clr && cnt[2*i] != '1) |=>
        ((cnt[2*i] != $past(cnt[2*i])) == ($past(bc_tick) && main_trig[i]))); // R9
    AST_CNT_TRACKS_OVL: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctr_clr && cnt[2*i+1] != '1) |=>
        ((cnt[2*i+1] != $past(cnt[2*i+1])) == ($past(bc_tick) && ovl_trig[i]))); // R9
  end
endmodule

bind pulse_width_sep pulse_width_sep_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bc_tick(bc_tick), .ctr_clr(ctr_clr),
  .main_trig(main_trig), .ovl_trig(ovl_trig), .cnt(cnt)
);

// File: tb/pulse_width_sep_bench.sv
module pulse_width_sep_bench;
  localparam int NCH = 8;
  localparam int CNT_W = 4;
  localparam int TW = 5;
  localparam int AW = $clog2(2*NCH);

  logic clk = 0, rst_n = 0, bc_tick = 0, ctr_clr = 0;
  logic [NCH-1:0] hit_in = '0;
  logic [TW-1:0] long_thr = TW'(15);
  logic [AW-1:0] rd_addr = '0;
  logic [NCH-1:0] main_trig, ovl_trig;
  logic [CNT_W-1:0] rd_data;

  int checks = 0, failures = 0;
  int hi_m [NCH];
  int hi_o [NCH];
  int phase = 0;
  bit main_during = 0;

  pulse_width_sep #(.NCH(NCH), .CNT_W(CNT_W), .TW(TW)) u_pulse_width_sep (
    .clk(clk), .rst_n(rst_n), .bc_tick(bc_tick), .hit_in(hit_in),
    .long_thr(long_thr), .ctr_clr(ctr_clr), .rd_addr(rd_addr),
    .main_trig(main_trig), .ovl_trig(ovl_trig), .rd_data(rd_data));

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (phase == 9) begin bc_tick = 1; phase = 0; end
    else begin bc_tick = 0; phase = phase + 1; end
    if (rst_n)
      for (int c = 0; c < NCH; c++) begin
        hi_m[c] = hi_m[c] + int'(main_trig[c]);
        hi_o[c] = hi_o[c] + int'(ovl_trig[c]);
      end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic rd(input int addr, output int v);
    rd_addr = AW'(addr);
    #1 v = int'(rd_data);
  endtask

  task automatic clear_all();
    @(negedge clk) ctr_clr = 1;
    @(negedge clk) ctr_clr = 0;
    for (int c = 0; c < NCH; c++) begin hi_m[c] = 0; hi_o[c] = 0; end
  endtask

  task automatic pulse(input int ch, input int w);
    main_during = 0;
    @(negedge clk) hit_in[ch] = 1;
    for (int j = 0; j < w; j++) begin
      @(negedge clk);
      if (main_trig[ch]) main_during = 1;
    end
    hit_in[ch] = 0;
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  task automatic expect_ch(input int ch, input int em, input int eo, input string tag);
    int vm, vo;
    rd(2*ch, vm);
    rd(2*ch+1, vo);
    check(vm == em, {tag, " main count"}, vm, em);
    check(vo == eo, {tag, " overlap count"}, vo, eo);
    check(hi_m[ch] == 10*em, {tag, " R6 main high cycles"}, hi_m[ch], 10*em);
    check(hi_o[ch] == 10*eo, {tag, " R6 overlap high cycles"}, hi_o[ch], 10*eo);
  endtask

  task automatic run_width(input int ch, input int w, input int em, input int eo, input string tag);
    clear_all();
    pulse(ch, w);
    settle();
    expect_ch(ch, em, eo, tag);
  endtask

  task automatic t_reset();
    int v;
    check(main_trig == '0 && ovl_trig == '0, "R1 outputs low", int'(main_trig | ovl_trig), 0);
    for (int a = 0; a < 2*NCH; a++) begin
      rd(a, v);
      check(v == 0, "R1 counter zero", v, 0);
    end
  endtask

  task automatic t_long();
    run_width(0, 15, 1, 0, "R2 width15");
    run_width(0, 40, 1, 0, "R2 width40");
    check(main_during, "R2 main before fall", int'(main_during), 1);
  endtask

  task automatic t_short();
    run_width(3, 6, 0, 1, "R3 width6");
    run_width(3, 14, 0, 1, "R3 width14");
  endtask

  task automatic t_glitch();
    run_width(4, 5, 0, 0, "R4 width5");
    run_width(4, 1, 0, 0, "R4 width1");
  endtask

  task automatic t_thr();
    long_thr = TW'(8);
    run_width(6, 8, 1, 0, "R5 thr8 width8");
    run_width(6, 7, 0, 1, "R5 thr8 width7");
    long_thr = TW'(15);
  endtask

  task automatic t_gap();
    clear_all();
    pulse(1, 20);
    @(negedge clk) hit_in[1] = 1;
    repeat (20) @(negedge clk);
    hit_in[1] = 0;
    settle();
    expect_ch(1, 1, 0, "R7 gap1 rejected");
    clear_all();
    pulse(1, 20);
    @(negedge clk);
    pulse(1, 20);
    settle();
    expect_ch(1, 2, 0, "R7 gap2 accepted");
  endtask

  task automatic t_multi();
    clear_all();
    fork
      pulse(2, 30);
      pulse(5, 10);
      pulse(7, 3);
    join
    settle();
    expect_ch(2, 1, 0, "R8 R9 ch2");
    expect_ch(5, 0, 1, "R8 R9 ch5");
    expect_ch(7, 0, 0, "R8 R9 ch7");
    expect_ch(0, 0, 0, "R8 ch0 untouched");
  endtask

  task automatic t_sat_clr();
    int v;
    clear_all();
    for (int n = 0; n < 20; n++) begin
      pulse(1, 20);
      repeat (25) @(negedge clk);
    end
    rd(2, v);
    check(v == 15, "R10 saturated", v, 15);
    @(negedge clk) ctr_clr = 1;
    @(negedge clk) ctr_clr = 0;
    rd(2, v);
    check(v == 0, "R11 cleared", v, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin hi_m[c] = 0; hi_o[c] = 0; end
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_long();
    t_short();
    t_glitch();
    t_thr();
    t_gap();
    t_multi();
    t_sat_clr();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule